// File: doc/BRIEF.md
# HDLC Bus Access Arbiter

This block decides when an HDLC transmitter may take a shared wired-AND bus, and it watches for collisions while the transmitter sends. The bus uses open-drain signalling, so a zero driven by any station pulls the bus low. A one is recessive. The block samples a bus-sense input and counts how many ones it has seen in a row. When that run is long enough, the block grants the framer's transmit request.

A fairness scheme uses two priority classes. A station in the normal class needs a run of eight ones before it may send. After a station finishes a frame it drops to the low class, and then it needs a run of ten ones. As soon as the station is granted access again, it returns to the normal class.

While the station is sending, the block compares each bit it drives with the level sensed on the bus. If the station drives a one and senses a zero, another station has won the bus. In that case the block releases the bus at once and reports the loss. Because a driven zero always wins, lower addresses have precedence within a class.

A two-bit select chooses how the bus is timed:
- 01: a bit is driven on the rising edge of the transmit clock and checked on the next falling edge.
- 11: a bit is driven on the falling edge and checked one full period later.
- Any other value turns off bus behaviour. A request is then granted at once, with no idle counting and no collision checks.

Top module: `hdlc_bus_arbiter`

## Requirements
- R1: In the normal class, with `tx_req` high, `granted` rises on the falling edge at which the eighth consecutive `cxd` sample of 1 is taken. No earlier sample grants access.
- R2: After `frame_end` is accepted while `granted` is high, the block enters the low class. The next grant then needs ten consecutive 1 samples on `cxd`.
- R3: Each grant puts the block back in the normal class.
- R4: A 0 sample on `cxd` clears the run of ones. The run saturates at ten, so a long idle bus still allows an immediate grant.
- R5: In bus modes (select 01 or 11), if `granted` is high, `txd` is 1 and `cxd` is sampled 0, the block acts on the same falling edge. It clears `granted`, pulses `lost` high for one cycle, and drives `txd` back to 1.
- R6: Neither a lost collision nor an abort changes the priority class. An abort is `tx_req` going low while `granted` is high, and it also clears `granted`.
- R7: With select 01, `txd` follows `tx_data` on rising clock edges. The collision check uses the falling edge half a period later.
- R8: With select 11, `txd` follows `tx_data` on falling clock edges, starting at the edge that grants access. The collision check uses the next falling edge.
- R9: With select 00 or 10, a request is granted on the first falling edge at which it is seen, whatever `cxd` shows. `lost` never rises.
- R10: A `frame_end` taken while `granted` is high clears `granted` and pulses `done` for one cycle.
- R11: While reset is asserted, `granted`, `lost` and `done` are 0, `txd` is 1, and the block is in the normal class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Timing select: 01 half-period check, 11 full-period check, others bus off |
| tx_req | input | 1 | Transmit request from the framer |
| tx_data | input | 1 | Serial bit from the framer |
| frame_end | input | 1 | Framer signals that the frame finished |
| cxd | input | 1 | Sensed bus level |
| txd | output | 1 | Bit driven onto the bus (1 = released) |
| granted | output | 1 | Transmission currently allowed |
| lost | output | 1 | One-cycle pulse on collision loss |
| done | output | 1 | One-cycle pulse on frame completion |

## Verification
A wrong run count or a wrong priority class appears only at the next grant. `granted` then rises one or more falling edges too early or too late, so such an error shows within ten cycles of the bus going idle. A stale or wrong collision state appears one falling edge after the conflicting bit. At that edge `lost` fails to pulse or `txd` keeps driving, and it is checked on the very next cycle. A timing-mode error moves `txd` by half a period, so it shows on the first driven bit.

// File: rtl/hdlc_bus_arbiter.sv
module hdlc_bus_arbiter #(
  parameter int NORMAL_ONES = 8,
  parameter int LOW_ONES    = 10,
  localparam int CW = $clog2(LOW_ONES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       tx_req,
  input  logic       tx_data,
  input  logic       frame_end,
  input  logic       cxd,
  output logic       txd,
  output logic       granted,
  output logic       lost,
  output logic       done
);

  logic [CW-1:0] ones_q, ones_d;
  logic low_q, low_d;
  logic grant_q, grant_d;
  logic lost_d, done_d;
  logic txd_r, txd_f;

  wire bus_mode = (mode == 2'b01) || (mode == 2'b11);
  wire late     = (mode == 2'b11);
  wire [CW-1:0] need = low_q ? CW'(LOW_ONES) : CW'(NORMAL_ONES);
  wire clash    = bus_mode && grant_q && txd && !cxd;

  assign ones_d = !cxd ? '0 : (ones_q == CW'(LOW_ONES)) ? ones_q : ones_q + 1'b1;

  always_comb begin
    grant_d = grant_q;
    low_d   = low_q;
    lost_d  = 1'b0;
    done_d  = 1'b0;
    if (grant_q) begin
      if (clash) begin
        grant_d = 1'b0;
        lost_d  = 1'b1;
      end else if (frame_end) begin
        grant_d = 1'b0;
        done_d  = 1'b1;
        low_d   = 1'b1;
      end else if (!tx_req) begin
        grant_d = 1'b0;
      end
    end else if (tx_req && (!bus_mode || ones_d >= need)) begin
      grant_d = 1'b1;
      low_d   = 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= '0;
      low_q   <= 1'b0;
      grant_q <= 1'b0;
      lost    <= 1'b0;
      done    <= 1'b0;
      txd_f   <= 1'b1;
    end else begin
      ones_q  <= ones_d;
      low_q   <= low_d;
      grant_q <= grant_d;
      lost    <= lost_d;
      done    <= done_d;
      txd_f   <= grant_d ? tx_data : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd_r <= 1'b1;
    else        txd_r <= grant_q ? tx_data : 1'b1;
  end

  assign txd     = late ? txd_f : txd_r;
  assign granted = grant_q;

endmodule

module hdlc_bus_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       tx_req,
  input logic       tx_data,
  input logic       frame_end,
  input logic       cxd,
  input logic       txd,
  input logic       granted,
  input logic       lost,
  input logic       done
);

  // R5
  lost_drops_grant_chk: assert property (@(negedge clk) disable iff (!rst_n)
    lost |-> !granted);

  // R5
  lost_single_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
    lost |=> !lost);

  // R10
  done_drops_grant_chk: assert property (@(negedge clk) disable iff (!rst_n)
    done |-> !granted);

  // R10
  done_single_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  no_loss_off_bus_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b10) |-> !lost);

  // R8
  released_late_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !granted) |-> txd);

  // R5
  loss_needs_conflict_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(granted));

endmodule

bind hdlc_bus_arbiter hdlc_bus_arbiter_chk u_chk (.*);

// File: tb/tb_hdlc_bus_arbiter.sv
`timescale 1ns/100ps
module tb_hdlc_bus_arbiter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic tx_req = 1'b0, tx_data = 1'b0, frame_end = 1'b0, other = 1'b1;
  logic txd, granted, lost, done;
  wire  cxd = txd & other;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  hdlc_bus_arbiter dut (.clk(clk), .rst_n(rst_n), .mode(mode), .tx_req(tx_req),
    .tx_data(tx_data), .frame_end(frame_end), .cxd(cxd), .txd(txd),
    .granted(granted), .lost(lost), .done(done));

  // behavioural reference
  int  m_run;
  bit  m_low, m_grant, m_lost, m_done, m_txr, m_txf;
  int  lost_seen, done_seen;

  function automatic bit exp_txd();
    return (mode == 2'b11) ? m_txf : m_txr;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_txr <= 1'b1;
    else        m_txr <= m_grant ? tx_data : 1'b1;
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 0; m_low <= 0; m_grant <= 0; m_lost <= 0; m_done <= 0; m_txf <= 1;
    end else begin
      automatic bit on_bus = (mode == 2'b01 || mode == 2'b11);
      automatic int run = cxd ? ((m_run >= 10) ? 10 : m_run + 1) : 0;
      automatic bit g = m_grant, lo = m_low, l = 0, d = 0;
      if (m_grant) begin
        if (on_bus && exp_txd() && !cxd) begin g = 0; l = 1; end
        else if (frame_end) begin g = 0; d = 1; lo = 1; end
        else if (!tx_req) g = 0;
      end else if (tx_req && (!on_bus || run >= (m_low ? 10 : 8))) begin
        g = 1; lo = 0;
      end
      m_run <= run; m_low <= lo; m_grant <= g; m_lost <= l; m_done <= d;
      m_txf <= g ? tx_data : 1'b1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R1/R2/R3/R4/R6/R9 granted", granted, m_grant);
    check("R5 lost", lost, m_lost);
    check("R10 done", done, m_done);
    check("R7/R8 txd", txd, exp_txd());
    if (lost) lost_seen++;
    if (done) done_seen++;
  endtask

  // dsel: 0 random, 1 zero, 2 one
  task automatic step(input bit req, input int dsel, input bit fe, input bit oth);
    @(negedge clk); #0.5;
    compare_all();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_req = req;
    tx_data = (dsel == 0) ? lfsr[0] : (dsel == 2);
    frame_end = fe;
    other = oth;
  endtask

  task automatic run(input int n, input bit req, input int dsel, input bit oth);
    for (int i = 0; i < n; i++) step(req, dsel, 1'b0, oth);
  endtask

  task automatic scenario(input logic [1:0] m);
    rst_n = 0; mode = m; tx_req = 0; tx_data = 0; frame_end = 0; other = 1;
    lost_seen = 0; done_seen = 0;
    repeat (2) @(negedge clk);
    #0.5;
    // R11 reset state
    check("R11 granted at reset", granted, 1'b0);
    check("R11 lost at reset", lost, 1'b0);
    check("R11 done at reset", done, 1'b0);
    check("R11 txd at reset", txd, 1'b1);
    rst_n = 1;
    // R1 and R4: a zero in the idle run restarts counting
    run(3, 1, 0, 1);
    run(1, 1, 0, 0);
    run(12, 1, 0, 1);
    // R7/R8: random payload, then a closing zero pair and the frame end (R10, R2)
    run(16, 1, 0, 1);
    run(2, 1, 1, 1);
    step(1, 1, 1'b1, 1);
    // R2/R3: ten ones needed from the low class
    run(14, 1, 1, 1);
    run(6, 1, 0, 1);
    // R5: another station pulls a driven one low
    run(3, 1, 2, 0);
    // R6: class stays as it was after a loss
    run(14, 1, 1, 1);
    run(4, 1, 0, 1);
    // R6: abort, then a saturated run allows an immediate grant (R4)
    run(14, 0, 1, 1);
    run(5, 1, 0, 1);
    run(2, 1, 1, 1);
    step(1, 1, 1'b1, 1);
    run(14, 1, 1, 1);
    run(2, 0, 1, 1);
    tests++;
    if ((m == 2'b01 || m == 2'b11) ? (lost_seen < 1) : (lost_seen != 0)) begin
      fails++;
      $display("FAIL R5/R9 mode %b: actual lost pulses %0d expected %s", m, lost_seen,
               (m == 2'b01 || m == 2'b11) ? ">=1" : "0");
    end
    tests++;
    if (done_seen < 2) begin
      fails++;
      $display("FAIL R10 mode %b: actual done pulses %0d expected >=2", m, done_seen);
    end
  endtask

  initial begin
    scenario(2'b01);
    scenario(2'b11);
    scenario(2'b00);
    scenario(2'b10);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule